// File: doc/BRIEF.md
# Hold Interpolator with Fourth-Order One-Bit Modulator

This block is the last digital stage of an oversampling audio converter. It accepts one 16-bit sample per channel at four or eight times the base sample rate, lifts the stream to a fixed 64-times rate by repeating each sample, and turns the result into a one-bit pulse-density stream per channel through a fourth-order noise-shaping loop. It runs on the 384-times master clock. A divider there produces the 64-times step enable. The mode input picks the repetition count, so the loop always steps at 64 times the base rate.

Upstream logic presents new samples on the data inputs. It reads the take strobe to know when the block has captured them. The two bitstreams are the observation taps for the modulator. A square 64-times reference clock is also provided so they can be probed. A single channel datapath holds one sample register and one modulator, and it is built once per stereo channel.

Top module: `sdm_interp_top`

## Requirements
- R1: `step_o` is high for exactly one cycle in every DIV (default 6) master-clock cycles. The first pulse comes in the sixth cycle after `rst` is released.
- R2: `obs_clk_o` is high for the first DIV/2 cycles of each divider period and low for the rest. It is therefore low in every cycle where `step_o` is high.
- R3: `take_o` is high only together with `step_o`. It is high on every 16th step when `rate_dbl`=0 and on every 8th step when `rate_dbl`=1. The first step after reset is a take.
- R4: When `rate_dbl` changes, the step phase counter keeps counting. It returns to zero at the step where it has reached or passed the new ratio minus one.
- R5: On a take cycle each channel captures its data input. The modulator uses the captured value from the next step until the following capture (zero-order hold). Data inputs are ignored on all other cycles.
- R6: On each step the four integrators I1..I4 are updated from their old values. I1 += x − fb, where x is the held two's-complement sample and fb is +32768 if the current output bit is 1 and −32768 if it is 0. Then I2 += I1, I3 += I2 and I4 += I3.
- R7: After an update, the output bit becomes 1 if I1 + I2/2 + I3/8 + I4/32 ≥ 0 (arithmetic right shifts by 0, 1, 3 and 5), and 0 otherwise. The bit changes only on step cycles.
- R8: If any updated integrator falls outside the signed ACC_W-bit range, all four integrators are cleared and the output bit becomes 1 instead of the normal update.
- R9: While `rst` is high (synchronous, active high), the divider, phase counter, held samples and integrators clear, and the output bits are 1. In the cycle after reset, `step_o` and `take_o` are 0 and `obs_clk_o` is 1.
- R10: The left and right channels are processed independently by identical datapaths and share only the step and take timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 384 times the base rate |
| rst | input | 1 | Synchronous active-high reset |
| rate_dbl | input | 1 | 0: inputs at 4x, hold 16 steps; 1: inputs at 8x, hold 8 steps |
| din_l | input | DATA_W | Left sample, two's complement |
| din_r | input | DATA_W | Right sample, two's complement |
| step_o | output | 1 | 64x step enable |
| take_o | output | 1 | Sample capture strobe |
| obs_clk_o | output | 1 | Square 64x reference clock for observation |
| bit_l_o | output | 1 | Left one-bit stream |
| bit_r_o | output | 1 | Right one-bit stream |

## Verification
The bench builds the block with DIV=6, the ratios 16 and 8, and DATA_W=16. It narrows ACC_W to 20 so that full-scale and random inputs drive the fourth-order loop into integrator saturation within a few hundred steps. This puts the clear-and-restart path of R8 within reach alongside ordinary noise shaping. Segments of constant extremes, silence, random data, mode toggling at an odd period and a mid-run reset are compared cycle by cycle against a reference model of the timing and loop equations.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    // Number of audio channels handled by the top level
    localparam int CHANNELS = 2;

    // Loop order and feedforward shifts of the weighted sum (1, 1/2, 1/8, 1/32)
    localparam int LOOP_ORDER = 4;
    localparam int FF_SHIFT [LOOP_ORDER] = '{0, 1, 3, 5};

    typedef enum logic {
        RATE_NORMAL = 1'b0,
        RATE_DOUBLE = 1'b1
    } rate_e;

    typedef struct packed {
        logic step;
        logic take;
        logic obs;
    } tick_t;

    function automatic int unsigned interp_ratio(input rate_e r,
                                                 input int unsigned norm,
                                                 input int unsigned dbl);
        return (r == RATE_DOUBLE) ? dbl : norm;
    endfunction

endpackage

// File: rtl/sdm_step_gen.sv
module sdm_step_gen #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst,
    output logic step,
    output logic obs
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= '0;
        else if (div_q == LAST)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign step = (div_q == LAST);
    assign obs  = (div_q < HALF);
endmodule

// File: rtl/sdm_phase_ctl.sv
module sdm_phase_ctl
    import sdm_pkg::*;
#(
    parameter int NORM_RATIO = 16,
    parameter int DBL_RATIO  = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  rate_e rate,
    output logic  take
);
    localparam int MAXR = (NORM_RATIO > DBL_RATIO) ? NORM_RATIO : DBL_RATIO;
    localparam int PW   = (MAXR > 2) ? $clog2(MAXR) : 1;

    logic [PW-1:0] ph_q;
    logic [PW-1:0] last;

    assign last = PW'(interp_ratio(rate, NORM_RATIO, DBL_RATIO) - 1);

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= '0;
        else if (step)
            ph_q <= (ph_q >= last) ? '0 : ph_q + 1'b1;
    end

    assign take = step && (ph_q == '0);
endmodule

// File: rtl/sdm_hold.sv
module sdm_hold #(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     take,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [DATA_W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (take)
            held <= din;
    end
endmodule

// File: rtl/sdm_mod4.sv
module sdm_mod4
    import sdm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     step,
    input  logic signed [DATA_W-1:0] sample,
    output logic                     bit_o
);
    localparam int EW = ACC_W + 2;
    localparam longint HI_L = (longint'(1) << (ACC_W - 1)) - 1;
    localparam longint LO_L = -(longint'(1) << (ACC_W - 1));
    localparam logic signed [EW-1:0] LIM_HI = EW'(HI_L);
    localparam logic signed [EW-1:0] LIM_LO = EW'(LO_L);
    localparam logic signed [EW-1:0] FS     = EW'(longint'(1) << (DATA_W - 1));

    logic signed [ACC_W-1:0] acc_q [LOOP_ORDER];
    logic signed [EW-1:0]    nxt   [LOOP_ORDER];
    logic signed [EW-1:0]    x, fb, wsum;
    logic                    ovf;
    logic                    bit_q;

    always_comb begin
        x  = EW'(sample);
        fb = bit_q ? FS : -FS;
        nxt[0] = EW'(acc_q[0]) + x - fb;
        for (int k = 1; k < LOOP_ORDER; k++)
            nxt[k] = EW'(acc_q[k]) + EW'(acc_q[k-1]);
        ovf  = 1'b0;
        wsum = '0;
        for (int k = 0; k < LOOP_ORDER; k++) begin
            if (nxt[k] > LIM_HI || nxt[k] < LIM_LO)
                ovf = 1'b1;
            wsum = wsum + (nxt[k] >>> FF_SHIFT[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || (step && ovf)) begin
            for (int k = 0; k < LOOP_ORDER; k++)
                acc_q[k] <= '0;
            bit_q <= 1'b1;
        end else if (step) begin
            for (int k = 0; k < LOOP_ORDER; k++)
                acc_q[k] <= nxt[k][ACC_W-1:0];
            bit_q <= ~wsum[EW-1];
        end
    end

    assign bit_o = bit_q;
endmodule

// File: rtl/sdm_interp_top.sv
module sdm_interp_top
    import sdm_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ACC_W      = 24,
    parameter int DIV        = 6,
    parameter int NORM_RATIO = 16,
    parameter int DBL_RATIO  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rate_dbl,
    input  logic signed [DATA_W-1:0] din_l,
    input  logic signed [DATA_W-1:0] din_r,
    output logic                     step_o,
    output logic                     take_o,
    output logic                     obs_clk_o,
    output logic                     bit_l_o,
    output logic                     bit_r_o
);
    tick_t                    tick;
    rate_e                    rate;
    logic signed [DATA_W-1:0] din_arr [CHANNELS];
    logic [CHANNELS-1:0]      bits;

    assign rate       = rate_e'(rate_dbl);
    assign din_arr[0] = din_l;
    assign din_arr[1] = din_r;

    sdm_step_gen #(.DIV(DIV)) u_step (
        .clk  (clk),
        .rst  (rst),
        .step (tick.step),
        .obs  (tick.obs)
    );

    sdm_phase_ctl #(.NORM_RATIO(NORM_RATIO), .DBL_RATIO(DBL_RATIO)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .step (tick.step),
        .rate (rate),
        .take (tick.take)
    );

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
        logic signed [DATA_W-1:0] held;

        sdm_hold #(.DATA_W(DATA_W)) u_hold (
            .clk  (clk),
            .rst  (rst),
            .take (tick.take),
            .din  (din_arr[ch]),
            .held (held)
        );

        sdm_mod4 #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mod (
            .clk    (clk),
            .rst    (rst),
            .step   (tick.step),
            .sample (held),
            .bit_o  (bits[ch])
        );
    end

    assign step_o    = tick.step;
    assign take_o    = tick.take;
    assign obs_clk_o = tick.obs;
    assign bit_l_o   = bits[0];
    assign bit_r_o   = bits[1];
endmodule

// File: rtl/sdm_checker.sv
module sdm_checker (
    input logic clk,
    input logic rst,
    input logic step_o,
    input logic take_o,
    input logic obs_clk_o,
    input logic bit_l_o,
    input logic bit_r_o
);
    AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        step_o |=> !step_o);  // R1

    AST_OBS_LOW_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        step_o |-> !obs_clk_o);  // R2

    AST_TAKE_NEEDS_STEP: assert property (@(posedge clk) disable iff (rst)
        take_o |-> step_o);  // R3

    AST_BITS_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        !step_o |=> $stable({bit_l_o, bit_r_o}));  // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!step_o && !take_o && bit_l_o && bit_r_o));  // R9
endmodule

bind sdm_interp_top sdm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .step_o    (step_o),
    .take_o    (take_o),
    .obs_clk_o (obs_clk_o),
    .bit_l_o   (bit_l_o),
    .bit_r_o   (bit_r_o)
);

// File: tb/tb_sdm_interp_top.sv
module tb_sdm_interp_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int ACC_W      = 20;
    localparam int DIV        = 6;
    localparam int NORM_R     = 16;
    localparam int DBL_R      = 8;
    localparam int SEG        = 2000;
    localparam int NSEG       = 8;
    localparam longint FS     = 32768;
    localparam longint LIM_HI = (longint'(1) << (ACC_W - 1)) - 1;
    localparam longint LIM_LO = -(longint'(1) << (ACC_W - 1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rate_dbl = 1'b0;
    logic signed [DATA_W-1:0] din_l = '0;
    logic signed [DATA_W-1:0] din_r = '0;
    logic step_o, take_o, obs_clk_o, bit_l_o, bit_r_o;

    sdm_interp_top #(
        .DATA_W(DATA_W), .ACC_W(ACC_W), .DIV(DIV),
        .NORM_RATIO(NORM_R), .DBL_RATIO(DBL_R)
    ) dut (
        .clk(clk), .rst(rst), .rate_dbl(rate_dbl),
        .din_l(din_l), .din_r(din_r),
        .step_o(step_o), .take_o(take_o), .obs_clk_o(obs_clk_o),
        .bit_l_o(bit_l_o), .bit_r_o(bit_r_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int n_clr  = 0;
    bit done   = 1'b0;
    bit rst_prev = 1'b1;

    // Reference model state (values of the design registers after the last edge)
    int     m_div   = 0;
    int     m_phase = 0;
    longint m_hold [2];
    longint m_i    [2][4];
    bit     m_bit  [2];

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        m_div   = 0;
        m_phase = 0;
        for (int c = 0; c < 2; c++) begin
            m_hold[c] = 0;
            m_bit[c]  = 1'b1;
            for (int k = 0; k < 4; k++) m_i[c][k] = 0;
        end
    endtask

    // Loop equations of R6, R7 and R8
    task automatic model_loop(input int c);
        longint n [4];
        longint fb, w;
        bit ovf;
        fb   = m_bit[c] ? FS : -FS;
        n[0] = m_i[c][0] + m_hold[c] - fb;
        n[1] = m_i[c][1] + m_i[c][0];
        n[2] = m_i[c][2] + m_i[c][1];
        n[3] = m_i[c][3] + m_i[c][2];
        ovf  = 1'b0;
        for (int k = 0; k < 4; k++)
            if (n[k] > LIM_HI || n[k] < LIM_LO) ovf = 1'b1;
        if (ovf) begin
            n_clr++;
            for (int k = 0; k < 4; k++) m_i[c][k] = 0;
            m_bit[c] = 1'b1;
        end else begin
            w = n[0] + (n[1] >>> 1) + (n[2] >>> 3) + (n[3] >>> 5);
            for (int k = 0; k < 4; k++) m_i[c][k] = n[k];
            m_bit[c] = (w >= 0);
        end
    endtask

    task automatic model_edge();
        bit en, tk;
        int ratio;
        if (rst) begin
            model_reset();
            return;
        end
        en = (m_div == DIV - 1);
        m_div = en ? 0 : m_div + 1;
        if (en) begin
            tk = (m_phase == 0);
            ratio = rate_dbl ? DBL_R : NORM_R;
            for (int c = 0; c < 2; c++) model_loop(c);
            if (tk) begin
                m_hold[0] = longint'(din_l);
                m_hold[1] = longint'(din_r);
            end
            m_phase = (m_phase >= ratio - 1) ? 0 : m_phase + 1;
        end
    endtask

    task automatic drive();
        int seg = cyc / SEG;
        rst = (cyc < 4) || (cyc >= 6 * SEG && cyc < 6 * SEG + 3);
        case (seg)
            0: begin rate_dbl = 1'b0; din_l = 16'($urandom()); din_r = 16'($urandom()); end
            1: begin rate_dbl = 1'b1; din_l = 16'($urandom()); din_r = 16'($urandom()); end
            2: begin rate_dbl = 1'b0; din_l = 16'sh7fff; din_r = -16'sh8000; end
            3: begin rate_dbl = 1'b1; din_l = -16'sh8000; din_r = 16'sh7fff; end
            4: begin rate_dbl = 1'b0; din_l = '0; din_r = '0; end
            5: begin
                // R4: mode flips at an odd period to land at every phase
                if (cyc % 37 == 0) rate_dbl = ~rate_dbl;
                din_l = 16'($urandom()); din_r = 16'($urandom());
            end
            6: begin rate_dbl = 1'b0; din_l = 16'($urandom()); din_r = 16'($urandom()); end
            default: begin
                rate_dbl = 1'b1;
                din_l = 16'($signed(12'($urandom())));
                din_r = 16'($signed(12'($urandom())));
            end
        endcase
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
    end

    always @(negedge clk) begin
        if (!done) begin
            if (rst_prev && !rst) begin
                chk("R9 step after reset", step_o, 0);
                chk("R9 take after reset", take_o, 0);
                chk("R9 obs_clk after reset", obs_clk_o, 1);
                chk("R9 bit_l after reset", bit_l_o, 1);
            end
            chk("R1 step_o", step_o, (m_div == DIV - 1));
            chk("R2 obs_clk_o", obs_clk_o, (m_div < DIV / 2));
            chk("R3/R4 take_o", take_o, (m_div == DIV - 1) && (m_phase == 0));
            chk("R5/R6/R7/R8 bit_l_o", bit_l_o, m_bit[0]);
            chk("R10 bit_r_o", bit_r_o, m_bit[1]);
            rst_prev = rst;
            if (cyc == SEG * NSEG) begin
                done = 1'b1;
                $display("note: integrator clears seen in model: %0d", n_clr);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
                $finish;
            end else begin
                drive();
                model_edge();
                cyc++;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule